// File: doc/BRIEF.md
# Inverter Leg Gate Guard

This block sits between a motor controller's switch commands and the gate enables of a three-phase bridge with one extra brake switch. Each phase has an active-low command for its upper and its lower switch. The block passes these commands to active-high gate enables and guards the bridge in two ways.

First, a phase whose two commands ask for conduction at the same time is locked off. The lock holds until the command that arrived later in the conflict asks again. Second, a sense input per switch shuts off that one switch once an overload has lasted a programmable number of cycles. That shutdown clears when the switch's own command next returns to inactive.

The brake switch only follows its command. A single registered active-low fault pin reports any active lock or shutdown. All inputs are asynchronous and pass through two-flop synchronizers. The block has no data stream, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `gate_guard`

## Requirements
- R1: While reset is asserted and right after it, all gate enables are 0 and `fault_n` is 1. A channel whose command has not been seen high (inactive) at least once since reset keeps its gate enable at 0, even when its command is low.
- R2: A gate enable is 1 only when its command was low three clock edges earlier (two synchronizer stages plus the output register). A command change at the pin appears on the gate enable at the third rising edge after it is sampled.
- R3: When the upper and lower commands of one phase are both requesting (low) in the same synchronized cycle, both gate enables of that phase go to 0 and `fault_n` goes to 0. The upper and lower gate enables of a phase are never 1 together.
- R4: A phase lock persists after both commands of that phase return high. Other phases keep following their commands.
- R5: A lock clears only on a new request (falling edge) of the command that fell later when the lock was taken. A falling edge of the other command does not clear it. If both fell in the same cycle, the upper command counts as the later one. If the clearing edge meets the other command still low, the phase locks again at once, with the clearing command now recorded as the later one.
- R6: A sense input held high for SC_DELAY consecutive synchronized cycles while its switch is requested turns off only that switch's gate enable and drives `fault_n` to 0. A pulse of exactly SC_DELAY cycles is enough.
- R7: A sense pulse shorter than SC_DELAY cycles has no effect on any gate enable or on `fault_n`.
- R8: An overload shutdown stays active until its switch's command goes high. After that, the next request turns the gate on again if sense is low.
- R9: The brake gate enable follows its command with the R2 latency. It has no interlock partner and no overload shutdown.
- R10: `fault_n` is 0 exactly when a lock or an overload shutdown is active. It changes at the same edge as the gate enables it accompanies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_cmd_n | input | N_PHASE | Upper-switch commands, low requests conduction |
| lo_cmd_n | input | N_PHASE | Lower-switch commands, low requests conduction |
| brk_cmd_n | input | 1 | Brake-switch command, low requests conduction |
| up_sense | input | N_PHASE | Upper-switch overload sense, high means overload |
| lo_sense | input | N_PHASE | Lower-switch overload sense, high means overload |
| up_gate | output | N_PHASE | Upper gate enables, high turns the switch on |
| lo_gate | output | N_PHASE | Lower gate enables, high turns the switch on |
| brk_gate | output | 1 | Brake gate enable |
| fault_n | output | 1 | Combined fault flag, active low, registered |

## Verification
A command edge is due on the gate enables at the third rising edge after sampling. A sense pulse acts at edge SC_DELAY+2, and lock or overload flags reach `fault_n` at the same edge as the gate drop. The bench changes inputs only on falling clock edges. Directed checks wait at least four cycles, or SC_DELAY+4 for overload cases, before sampling settled values. A cycle-accurate bench model built from the requirements is also compared against every output on every falling edge, so each latency is checked to the exact cycle under random stimulus.

// File: rtl/gg_pkg.sv
package gg_pkg;
  // which command of a phase arrived last when a lock was taken
  typedef enum logic {LATER_UP = 1'b0, LATER_LO = 1'b1} later_e;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[DEPTH-2:0], d};
  end

  assign q = st[DEPTH-1];
endmodule

// File: rtl/gg_leg_lock.sv
module gg_leg_lock
  import gg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_up,
  input  logic req_lo,
  output logic lock_nx
);
  logic   up_prev, lo_prev, lock_q;
  later_e who_q, who_d;
  logic   up_rise, lo_rise, clash, release_hit;

  always_comb begin
    up_rise     = req_up & ~up_prev;
    lo_rise     = req_lo & ~lo_prev;
    clash       = req_up & req_lo;
    release_hit = lock_q & ((who_q == LATER_LO) ? lo_rise : up_rise);
    lock_nx     = lock_q ? (~release_hit | clash) : clash;
    who_d       = who_q;
    if (clash && (!lock_q || release_hit))
      who_d = (lo_rise && !up_rise) ? LATER_LO : LATER_UP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev <= 1'b0;
      lo_prev <= 1'b0;
      lock_q  <= 1'b0;
      who_q   <= LATER_UP;
    end else begin
      up_prev <= req_up;
      lo_prev <= req_lo;
      lock_q  <= lock_nx;
      who_q   <= who_d;
    end
  end
endmodule

// File: rtl/gg_sc_timer.sv
module gg_sc_timer #(
  parameter int unsigned DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense,
  input  logic req,
  output logic flag_nx
);
  localparam int unsigned CW = ($clog2(DELAY) > 0) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LIM = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q, hit;

  assign hit     = sense & (cnt_q == LIM);
  assign flag_nx = req & (hit | flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      if (!sense)            cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gate_guard.sv
module gate_guard
  import gg_pkg::*;
#(
  parameter int unsigned N_PHASE  = 3,
  parameter int unsigned SC_DELAY = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PHASE-1:0] up_cmd_n,
  input  logic [N_PHASE-1:0] lo_cmd_n,
  input  logic               brk_cmd_n,
  input  logic [N_PHASE-1:0] up_sense,
  input  logic [N_PHASE-1:0] lo_sense,
  output logic [N_PHASE-1:0] up_gate,
  output logic [N_PHASE-1:0] lo_gate,
  output logic               brk_gate,
  output logic               fault_n
);
  localparam int unsigned NSW = 2 * N_PHASE;
  localparam int unsigned NCH = NSW + 1;

  logic [NCH-1:0]     cmd_s, arm_q, req;
  logic [NSW-1:0]     sense_s, sc_nx;
  logic [N_PHASE-1:0] lock_nx;
  logic [N_PHASE-1:0] up_gate_d, lo_gate_d;
  logic               brk_gate_d, fault_n_d;

  gg_sync #(.W(NCH), .DEPTH(SYNC_DEPTH)) i_cmd_sync (
    .clk(clk), .rst_n(rst_n), .d({brk_cmd_n, lo_cmd_n, up_cmd_n}), .q(cmd_s));

  gg_sync #(.W(NSW), .DEPTH(SYNC_DEPTH)) i_sense_sync (
    .clk(clk), .rst_n(rst_n), .d({lo_sense, up_sense}), .q(sense_s));

  // a channel is armed once its synchronized command has been seen inactive
  assign req = arm_q & ~cmd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_q | cmd_s;
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    gg_leg_lock i_lock (
      .clk(clk), .rst_n(rst_n),
      .req_up(req[p]), .req_lo(req[N_PHASE+p]), .lock_nx(lock_nx[p]));
  end

  for (genvar k = 0; k < NSW; k++) begin : g_switch
    gg_sc_timer #(.DELAY(SC_DELAY)) i_sc (
      .clk(clk), .rst_n(rst_n),
      .sense(sense_s[k]), .req(req[k]), .flag_nx(sc_nx[k]));
  end

  always_comb begin
    up_gate_d  = req[N_PHASE-1:0]   & ~lock_nx & ~sc_nx[N_PHASE-1:0];
    lo_gate_d  = req[NSW-1:N_PHASE] & ~lock_nx & ~sc_nx[NSW-1:N_PHASE];
    brk_gate_d = req[NCH-1];
    fault_n_d  = ~(|{lock_nx, sc_nx});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_gate  <= '0;
      lo_gate  <= '0;
      brk_gate <= 1'b0;
      fault_n  <= 1'b1;
    end else begin
      up_gate  <= up_gate_d;
      lo_gate  <= lo_gate_d;
      brk_gate <= brk_gate_d;
      fault_n  <= fault_n_d;
    end
  end
endmodule

// File: rtl/gate_guard_chk.sv
module gate_guard_chk #(
  parameter int unsigned N_PHASE = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PHASE-1:0] up_cmd_n,
  input logic [N_PHASE-1:0] lo_cmd_n,
  input logic               brk_cmd_n,
  input logic [N_PHASE-1:0] up_gate,
  input logic [N_PHASE-1:0] lo_gate,
  input logic               brk_gate,
  input logic               fault_n
);
  // R1: reset leaves every gate off and no fault
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (up_gate == '0 && lo_gate == '0 && !brk_gate && fault_n));

  // R3: never both switches of a phase on
  a_r3_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (up_gate & lo_gate) == '0);

  // R2: upper gate on only if requested three edges earlier
  a_r2_up_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (up_gate & $past(up_cmd_n, 3)) == '0);

  // R2: lower gate on only if requested three edges earlier
  a_r2_lo_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate & $past(lo_cmd_n, 3)) == '0);

  // R9: brake gate on only if requested three edges earlier
  a_r9_brake_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    brk_gate |-> !$past(brk_cmd_n, 3));
endmodule

bind gate_guard gate_guard_chk #(.N_PHASE(N_PHASE)) i_gate_guard_chk (
  .clk(clk), .rst_n(rst_n), .up_cmd_n(up_cmd_n), .lo_cmd_n(lo_cmd_n),
  .brk_cmd_n(brk_cmd_n), .up_gate(up_gate), .lo_gate(lo_gate),
  .brk_gate(brk_gate), .fault_n(fault_n));

// File: tb/test_gate_guard.sv
`timescale 1ns/1ps
module test_gate_guard;
  localparam int NP  = 3;
  localparam int DLY = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] up_n = '1, lo_n = '1, us = '0, ls = '0;
  logic brk_n = 1'b1;
  logic [NP-1:0] up_gate, lo_gate;
  logic brk_gate, fault_n;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gate_guard #(.N_PHASE(NP), .SC_DELAY(DLY)) i_gate_guard (
    .clk(clk), .rst_n(rst_n), .up_cmd_n(up_n), .lo_cmd_n(lo_n), .brk_cmd_n(brk_n),
    .up_sense(us), .lo_sense(ls), .up_gate(up_gate), .lo_gate(lo_gate),
    .brk_gate(brk_gate), .fault_n(fault_n));

  // cycle model of the requirements
  bit [2*NP:0]   m_c1, m_c2, m_arm;
  bit [2*NP-1:0] m_s1, m_s2, m_sc;
  bit [NP-1:0]   m_lock, m_who, m_uprev, m_lprev;
  int            m_cnt [2*NP];
  bit [NP-1:0]   e_up, e_lo;
  bit            e_brk, e_fn = 1'b1;

  task automatic model_step();
    bit [2*NP:0]   req;
    bit [NP-1:0]   lk;
    bit [2*NP-1:0] scn;
    req = m_arm & ~m_c2;
    for (int p = 0; p < NP; p++) begin
      bit u, l, ur, lr, clash, rel;
      u = req[p]; l = req[NP+p];
      ur = u & ~m_uprev[p]; lr = l & ~m_lprev[p];
      clash = u & l;
      rel = m_lock[p] & (m_who[p] ? lr : ur);
      lk[p] = m_lock[p] ? (!rel || clash) : clash;
      if (clash && (!m_lock[p] || rel)) m_who[p] = lr && !ur;
      m_uprev[p] = u; m_lprev[p] = l;
    end
    for (int k = 0; k < 2*NP; k++) begin
      bit hit;
      hit = m_s2[k] && (m_cnt[k] == DLY-1);
      scn[k] = req[k] && (hit || m_sc[k]);
      if (!m_s2[k]) m_cnt[k] = 0;
      else if (m_cnt[k] != DLY-1) m_cnt[k]++;
    end
    m_lock = lk; m_sc = scn; m_arm = m_arm | m_c2;
    e_up  = req[NP-1:0] & ~lk & ~scn[NP-1:0];
    e_lo  = req[2*NP-1:NP] & ~lk & ~scn[2*NP-1:NP];
    e_brk = req[2*NP];
    e_fn  = !(|lk || |scn);
    m_c2 = m_c1; m_c1 = {brk_n, lo_n, up_n};
    m_s2 = m_s1; m_s1 = {ls, us};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 = '0; m_c2 = '0; m_arm = '0; m_s1 = '0; m_s2 = '0; m_sc = '0;
      m_lock = '0; m_who = '0; m_uprev = '0; m_lprev = '0;
      for (int k = 0; k < 2*NP; k++) m_cnt[k] = 0;
      e_up = '0; e_lo = '0; e_brk = 1'b0; e_fn = 1'b1;
    end else model_step();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 upper gates", 32'(up_gate), 32'(e_up));
    chk("R2 lower gates", 32'(lo_gate), 32'(e_lo));
    chk("R9 brake gate", 32'(brk_gate), 32'(e_brk));
    chk("R10 fault flag", 32'(fault_n), 32'(e_fn));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd17));
    up_n = 3'b110; brk_n = 1'b0;            // held low from reset: unarmed
    tick(3);
    chk("R1 reset up", 32'(up_gate), 0);
    chk("R1 reset fault_n", 32'(fault_n), 1);
    rst_n = 1'b1;
    tick(6);
    chk("R1 unarmed upper", 32'(up_gate[0]), 0);
    chk("R1 unarmed brake", 32'(brk_gate), 0);
    up_n = 3'b111; brk_n = 1'b1; tick(4);
    up_n[0] = 1'b0; brk_n = 1'b0; tick(4);
    chk("R2 armed upper on", 32'(up_gate[0]), 1);
    chk("R9 brake on", 32'(brk_gate), 1);
    // R2 latency: visible at third falling edge
    lo_n[1] = 1'b0; tick(2);
    chk("R2 not yet", 32'(lo_gate[1]), 0);
    tick(1);
    chk("R2 on at third edge", 32'(lo_gate[1]), 1);
    // R3: upper arrives later on phase 1
    tick(2); up_n[1] = 1'b0; tick(4);
    chk("R3 upper off", 32'(up_gate[1]), 0);
    chk("R3 lower off", 32'(lo_gate[1]), 0);
    chk("R3 fault", 32'(fault_n), 0);
    chk("R4 other phase", 32'(up_gate[0]), 1);
    up_n[1] = 1'b1; lo_n[1] = 1'b1; tick(4);
    chk("R4 latched", 32'(fault_n), 0);
    lo_n[1] = 1'b0; tick(4);
    chk("R5 earlier edge keeps lock", 32'(fault_n), 0);
    chk("R5 lower still off", 32'(lo_gate[1]), 0);
    lo_n[1] = 1'b1; tick(4);
    up_n[1] = 1'b0; tick(4);
    chk("R5 later edge clears", 32'(fault_n), 1);
    chk("R5 gate follows", 32'(up_gate[1]), 1);
    up_n[1] = 1'b1; tick(4);
    // R5 retrip on phase 2: lower later
    up_n[2] = 1'b0; tick(4); lo_n[2] = 1'b0; tick(4);
    chk("R3 phase2 lock", 32'(fault_n), 0);
    up_n[2] = 1'b1; lo_n[2] = 1'b1; tick(4);
    up_n[2] = 1'b0; tick(4);
    lo_n[2] = 1'b0; tick(4);
    chk("R5 retrip fault", 32'(fault_n), 0);
    chk("R5 retrip gates", 32'({up_gate[2], lo_gate[2]}), 0);
    up_n[2] = 1'b1; lo_n[2] = 1'b1; tick(4);
    lo_n[2] = 1'b0; tick(4);
    chk("R5 clear after retrip", 32'(fault_n), 1);
    chk("R5 lower follows", 32'(lo_gate[2]), 1);
    lo_n[2] = 1'b1; tick(4);
    // R6: overload on upper 0
    us[0] = 1'b1; tick(DLY + 4);
    chk("R6 upper shut", 32'(up_gate[0]), 0);
    chk("R6 fault", 32'(fault_n), 0);
    chk("R6 brake unaffected", 32'(brk_gate), 1);
    us[0] = 1'b0; tick(4);
    chk("R8 held while requested", 32'(up_gate[0]), 0);
    up_n[0] = 1'b1; tick(4);
    chk("R8 release", 32'(fault_n), 1);
    up_n[0] = 1'b0; tick(4);
    chk("R8 back on", 32'(up_gate[0]), 1);
    // R7: one cycle short
    us[0] = 1'b1; tick(DLY - 1); us[0] = 1'b0; tick(6);
    chk("R7 short pulse gate", 32'(up_gate[0]), 1);
    chk("R7 short pulse fault", 32'(fault_n), 1);
    // R6 boundary: exactly DLY cycles
    us[0] = 1'b1; tick(DLY); us[0] = 1'b0; tick(4);
    chk("R6 exact pulse trips", 32'(up_gate[0]), 0);
    up_n[0] = 1'b1; tick(4);
    // random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(7) == 0) up_n[p] = ~up_n[p];
        if ($urandom_range(7) == 0) lo_n[p] = ~lo_n[p];
        if ($urandom_range(15) == 0) us[p] = ~us[p];
        if ($urandom_range(15) == 0) ls[p] = ~ls[p];
      end
      if ($urandom_range(9) == 0) brk_n = ~brk_n;
      tick(1);
    end
    finish_run();
  end
endmodule